// File: doc/BRIEF.md
# Multi-Channel Conversion Scheduler

This block drives one shared converter across three measurement channels: shunt voltage (channel 0), bus voltage (channel 1) and die temperature (channel 2). A single configuration write sets the enabled channels, the run style (free-running loop or single-shot), the averaging depth and a conversion-time code for each channel. The block requests conversions one channel at a time. For each request it passes the channel's time code to the converter and waits for the converter's done pulse and sample.

With no averaging, each sample goes straight to that channel's result register. With averaging, the samples are summed per channel over the programmed number of passes, and the rounded-down mean is published only when the last pass ends. A start delay, counted in prescaled ticks, can hold back the first conversion after a configuration write so that several monitors can be aligned in time. A sticky ready flag marks each completed sequence. A status read clears it, and so does a configuration write that enables channels. A write that selects shutdown leaves it alone.

Top module: `meas_seq_ctrl`

## Requirements
- R1: After reset, `ready` is 0 and all three results are 0. The reset configuration is free-running, all channels enabled, averaging code 0, all time codes 0 and delay 0, so the first conversion request goes to channel 0 within a few cycles.
- R2: Within a pass, the enabled channels are requested in rising channel order and disabled channels are skipped. Each `cnv_start` is a one-cycle pulse. `cnv_time` carries that channel's code, taken from `cfg_wdata` bits [9:7] for channel 0, [12:10] for channel 1 and [15:13] for channel 2.
- R3: With averaging code 0, a channel's result takes the converter sample on the clock edge where `cnv_done` is seen for that channel.
- R4: The averaging code in `cfg_wdata` [6:4] selects 1, 4, 16, 64, 128, 256, 512 or 1024 passes for codes 0 to 7. For codes above 0, the result becomes the per-channel sum divided by the count, rounded toward minus infinity (arithmetic shift). It is published at sequence end and stays unchanged before that.
- R5: A result keeps its value until a newly completed result replaces it. This holds for disabled channels and for all channels while shut down.
- R6: `cfg_wdata` [2:0] enables channels 0, 1 and 2, and bit 3 selects free-running (1) or single-shot (0). A value of 0 in bits [2:0] means shutdown. Free-running repeats the sequence without end. Single-shot runs one full sequence and then issues no more requests until the next configuration write.
- R7: Every `cfg_wr` aborts the work in progress. It discards partial sums and ignores any late done from the old request, then restarts from the first enabled channel and pass 0.
- R8: `ready` goes to 1 one cycle after the final done of a sequence, in the same cycle the averaged results appear.
- R9: `ready` clears on `stat_rd`, and on a `cfg_wr` with nonzero enables. A `cfg_wr` that selects shutdown leaves it unchanged. If a sequence completes in the same cycle as `stat_rd`, `ready` is set.
- R10: A delay value D, written through `dly_wr`, postpones the first request after each configuration write by exactly D × TICK_DIV cycles compared with D = 0. Writing the delay never starts or restarts conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Mode, averaging code and time codes |
| dly_wr | input | 1 | Delay register write strobe |
| dly_wdata | input | DLY_W | Start delay in prescaled ticks |
| stat_rd | input | 1 | Status read strobe, clears ready |
| ready | output | 1 | Sequence-complete flag |
| cnv_start | output | 1 | Conversion request pulse |
| cnv_chan | output | 2 | Channel for the request |
| cnv_time | output | 3 | Conversion-time code for the request |
| cnv_done | input | 1 | Converter done pulse |
| cnv_data | input | DATA_W | Converter sample, two's complement |
| res_shunt | output | DATA_W | Published shunt result |
| res_bus | output | DATA_W | Published bus result |
| res_temp | output | DATA_W | Published temperature result |

## Verification
A converter model answers each request after a delay set by its time code and returns a linear ramp per channel. Distinct channel values and a sparse enable pattern (channels 0 and 2) show whether the scheduling order, channel skipping and time-code routing are correct. A negative rising ramp averaged over four passes produces a mean that differs between floor rounding and rounding toward zero. A 1024-pass ramp exercises the widest accumulator and the largest shift. Aborting a free-running sequence with large values, then restarting with a small constant, exposes any partial sum that survived the abort. Latencies measured with and without a start delay isolate the delay term.

// File: rtl/meas_seq_pkg.sv
// Package: shared constants, state type and channel-walk helpers for the
// conversion scheduler. Assumes channel 0 is always the lowest index.
package meas_seq_pkg;

    localparam int NUM_CH      = 3;
    localparam int CH_W        = 2;
    localparam int MODE_W      = 4;
    localparam int AVG_W       = 3;
    localparam int TCODE_W     = 3;
    localparam int AVG_MAX_LOG = 10;
    localparam int CFG_W       = MODE_W + AVG_W + NUM_CH * TCODE_W;

    typedef enum logic [2:0] {
        S_OFF,
        S_DELAY,
        S_START,
        S_WAIT,
        S_PUBLISH
    } seq_state_e;

    // Lowest enabled channel index (0 when none are enabled).
    function automatic logic [CH_W-1:0] first_chan(input logic [NUM_CH-1:0] en);
        logic [CH_W-1:0] r;
        r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (en[i]) r = CH_W'(i);
        end
        return r;
    endfunction

    // {found, index} of the next enabled channel above cur.
    function automatic logic [CH_W:0] next_chan(input logic [NUM_CH-1:0] en,
                                                input logic [CH_W-1:0]   cur);
        logic [CH_W:0] r;
        r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (en[i] && (i > int'(cur))) r = {1'b1, CH_W'(i)};
        end
        return r;
    endfunction

    // Averaging code to log2 of pass count: 1,4,16,64,128,256,512,1024.
    function automatic logic [3:0] avg_shift(input logic [AVG_W-1:0] code);
        case (code)
            3'd0:    return 4'd0;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            3'd3:    return 4'd6;
            3'd4:    return 4'd7;
            3'd5:    return 4'd8;
            3'd6:    return 4'd9;
            default: return 4'd10;
        endcase
    endfunction

endpackage

// File: rtl/meas_delay_timer.sv
// Start-delay timer: loads a tick count and counts it down, one tick per
// TICK_DIV clocks. expired is high whenever the count is zero.
// Assumes load is a single-cycle strobe from the sequencer.
module meas_delay_timer #(
    parameter int DLY_W    = 8,
    parameter int TICK_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             expired
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [DLY_W-1:0] ticks_q;
    logic [PRE_W-1:0] pre_q;

    // Prescaler and tick down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks_q <= '0;
            pre_q   <= '0;
        end else if (load) begin
            ticks_q <= load_val;
            pre_q   <= '0;
        end else if (ticks_q != '0) begin
            if (pre_q == PRE_W'(TICK_DIV - 1)) begin
                pre_q   <= '0;
                ticks_q <= ticks_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // Expiry flag for the sequencer.
    always_comb expired = (ticks_q == '0);

endmodule

// File: rtl/meas_chan_accum.sv
// Per-channel sum and result register. On a sample, the first pass loads
// the sum and later passes add to it. pub_raw copies the sample straight
// to the result; pub_avg publishes sum >>> shift (floor of the mean).
// Assumes pub_raw and pub_avg are never high together.
module meas_chan_accum #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic              smp_first,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              pub_raw,
    input  logic              pub_avg,
    input  logic [3:0]        shift,
    output logic [DATA_W-1:0] result
);
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] smp_ext;
    logic signed [ACC_W-1:0] mean;

    // Sign-extend the sample and form the shifted mean.
    always_comb begin
        smp_ext = {{(ACC_W - DATA_W){smp_data[DATA_W-1]}}, smp_data};
        mean    = acc_q >>> shift;
    end

    // Running sum over passes.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (smp_en)  acc_q <= smp_first ? smp_ext : acc_q + smp_ext;
    end

    // Published result register.
    always_ff @(posedge clk) begin
        if (!rst_n)       result <= '0;
        else if (pub_raw) result <= smp_data;
        else if (pub_avg) result <= mean[DATA_W-1:0];
    end

endmodule

// File: rtl/meas_seq_ctrl.sv
// Conversion scheduler top: walks the enabled channels on a shared
// converter, repeats passes for averaging, publishes results, runs a
// start delay and keeps the ready flag. Assumes the converter restarts
// on every cnv_start and returns exactly one cnv_done per request.
module meas_seq_ctrl
    import meas_seq_pkg::*;
#(
    parameter int              DATA_W   = 16,
    parameter int              DLY_W    = 8,
    parameter int              TICK_DIV = 16,
    parameter logic [MODE_W-1:0] RST_MODE = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              dly_wr,
    input  logic [DLY_W-1:0]  dly_wdata,
    input  logic              stat_rd,
    output logic              ready,
    output logic              cnv_start,
    output logic [CH_W-1:0]   cnv_chan,
    output logic [TCODE_W-1:0] cnv_time,
    input  logic              cnv_done,
    input  logic [DATA_W-1:0] cnv_data,
    output logic [DATA_W-1:0] res_shunt,
    output logic [DATA_W-1:0] res_bus,
    output logic [DATA_W-1:0] res_temp
);
    localparam int ACC_W   = DATA_W + AVG_MAX_LOG;
    localparam int PASS_W  = AVG_MAX_LOG;
    localparam int AVG_LSB = MODE_W;
    localparam int TC_LSB  = MODE_W + AVG_W;

    seq_state_e                  state;
    logic [NUM_CH-1:0]           en_q;
    logic                        cont_q;
    logic [AVG_W-1:0]            avg_q;
    logic [NUM_CH*TCODE_W-1:0]   tcode_q;
    logic [DLY_W-1:0]            dly_q;
    logic [CH_W-1:0]             cur_ch;
    logic [PASS_W-1:0]           pass_cnt;
    logic                        ready_q;

    logic [NUM_CH-1:0]           wr_en;
    logic [3:0]                  sh;
    logic [PASS_W:0]             n_full;
    logic                        pass_last;
    logic [CH_W:0]               nxt;
    logic                        dly_expired;
    logic                        pub_now;
    logic [DATA_W-1:0]           res_q [NUM_CH];

    // Decode of write data and pass bookkeeping.
    always_comb begin
        wr_en     = cfg_wdata[NUM_CH-1:0];
        sh        = avg_shift(avg_q);
        n_full    = (PASS_W + 1)'(1) << sh;
        pass_last = ({1'b0, pass_cnt} == (n_full - 1'b1));
        nxt       = next_chan(en_q, cur_ch);
        pub_now   = (state == S_PUBLISH) && !cfg_wr;
    end

    // Delay register; a write here never restarts anything.
    always_ff @(posedge clk) begin
        if (!rst_n)      dly_q <= '0;
        else if (dly_wr) dly_q <= dly_wdata;
    end

    meas_delay_timer #(
        .DLY_W    (DLY_W),
        .TICK_DIV (TICK_DIV)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_wr),
        .load_val (dly_q),
        .expired  (dly_expired)
    );

    // Sequencer state machine and configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= (RST_MODE[NUM_CH-1:0] != '0) ? S_DELAY : S_OFF;
            en_q     <= RST_MODE[NUM_CH-1:0];
            cont_q   <= RST_MODE[MODE_W-1];
            avg_q    <= '0;
            tcode_q  <= '0;
            cur_ch   <= first_chan(RST_MODE[NUM_CH-1:0]);
            pass_cnt <= '0;
        end else if (cfg_wr) begin
            en_q     <= wr_en;
            cont_q   <= cfg_wdata[MODE_W-1];
            avg_q    <= cfg_wdata[AVG_LSB +: AVG_W];
            tcode_q  <= cfg_wdata[TC_LSB +: NUM_CH*TCODE_W];
            cur_ch   <= first_chan(wr_en);
            pass_cnt <= '0;
            state    <= (wr_en != '0) ? S_DELAY : S_OFF;
        end else begin
            case (state)
                S_DELAY: if (dly_expired) state <= S_START;
                S_START: state <= S_WAIT;
                S_WAIT: begin
                    if (cnv_done) begin
                        if (nxt[CH_W]) begin
                            cur_ch <= nxt[CH_W-1:0];
                            state  <= S_START;
                        end else if (pass_last) begin
                            state <= S_PUBLISH;
                        end else begin
                            pass_cnt <= pass_cnt + 1'b1;
                            cur_ch   <= first_chan(en_q);
                            state    <= S_START;
                        end
                    end
                end
                S_PUBLISH: begin
                    pass_cnt <= '0;
                    cur_ch   <= first_chan(en_q);
                    state    <= cont_q ? S_START : S_OFF;
                end
                default: state <= S_OFF;
            endcase
        end
    end

    // Ready flag: completion sets, status read or enabling write clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  ready_q <= 1'b0;
        else if (pub_now)                            ready_q <= 1'b1;
        else if (stat_rd || (cfg_wr && wr_en != '0)) ready_q <= 1'b0;
    end

    // Converter request outputs.
    always_comb begin
        cnv_start = (state == S_START);
        cnv_chan  = cur_ch;
        cnv_time  = tcode_q[int'(cur_ch) * TCODE_W +: TCODE_W];
        ready     = ready_q;
    end

    // One accumulator and result register per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic smp_en;
        always_comb smp_en = (state == S_WAIT) && cnv_done && !cfg_wr &&
                             (cur_ch == CH_W'(c));
        meas_chan_accum #(
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
        ) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_en    (smp_en),
            .smp_first (pass_cnt == '0),
            .smp_data  (cnv_data),
            .pub_raw   (smp_en && (sh == 4'd0)),
            .pub_avg   (pub_now && (sh != 4'd0) && en_q[c]),
            .shift     (sh),
            .result    (res_q[c])
        );
    end

    assign res_shunt = res_q[0];
    assign res_bus   = res_q[1];
    assign res_temp  = res_q[2];

endmodule

// File: rtl/meas_seq_ctrl_chk.sv
// Checker for the conversion scheduler: request pulses, enabled-channel
// requests, shutdown behaviour and ready-flag clearing. Bound to every
// instance of the top module.
module meas_seq_ctrl_chk
    import meas_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic              stat_rd,
    input logic              ready,
    input logic              cnv_start,
    input logic [CH_W-1:0]   cnv_chan,
    input logic [NUM_CH-1:0] en_q
);
    // R2: every request targets an enabled channel.
    assert_start_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> en_q[cnv_chan]);

    // R2: a request lasts one cycle.
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start);

    // R6: a shutdown write stops requests.
    assert_off_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[NUM_CH-1:0] == '0) |=> !cnv_start);

    // R9: an enabling write clears ready.
    assert_ready_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[NUM_CH-1:0] != '0) |=> !ready);

    // R9: a shutdown write leaves ready as it was.
    assert_ready_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[NUM_CH-1:0] == '0 && !stat_rd) |=> $stable(ready));

endmodule

bind meas_seq_ctrl meas_seq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .stat_rd   (stat_rd),
    .ready     (ready),
    .cnv_start (cnv_start),
    .cnv_chan  (cnv_chan),
    .en_q      (en_q)
);

// File: tb/meas_seq_ctrl_test.sv
module meas_seq_ctrl_test;
    localparam int DATA_W = 16;
    localparam int TICK   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [15:0]       cfg_wdata = '0;
    logic              dly_wr = 1'b0;
    logic [7:0]        dly_wdata = '0;
    logic              stat_rd = 1'b0;
    logic              ready;
    logic              cnv_start;
    logic [1:0]        cnv_chan;
    logic [2:0]        cnv_time;
    logic              cnv_done = 1'b0;
    logic [DATA_W-1:0] cnv_data = '0;
    logic [DATA_W-1:0] res_shunt, res_bus, res_temp;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    meas_seq_ctrl #(.DATA_W(DATA_W), .DLY_W(8), .TICK_DIV(TICK)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .dly_wr(dly_wr), .dly_wdata(dly_wdata), .stat_rd(stat_rd),
        .ready(ready), .cnv_start(cnv_start), .cnv_chan(cnv_chan),
        .cnv_time(cnv_time), .cnv_done(cnv_done), .cnv_data(cnv_data),
        .res_shunt(res_shunt), .res_bus(res_bus), .res_temp(res_temp)
    );

    // Converter model: ramp per channel, restart on each request.
    int       base [3];
    int       inc  [3];
    int       epoch = 0;
    int       seen_epoch = 0;
    int       smp  [3];
    int       start_cnt = 0;
    logic [1:0] log_ch [64];
    logic [2:0] log_t  [64];
    logic       busy = 1'b0;
    int         cnt = 0;
    logic [1:0] cur = '0;

    initial begin
        for (int i = 0; i < 3; i++) begin base[i] = 0; inc[i] = 0; smp[i] = 0; end
    end

    always @(posedge clk) begin
        cnv_done <= 1'b0;
        if (cnv_start) begin
            busy <= 1'b1;
            cnt  <= int'(cnv_time) + 1;
            cur  <= cnv_chan;
            log_ch[start_cnt % 64] <= cnv_chan;
            log_t[start_cnt % 64]  <= cnv_time;
            start_cnt <= start_cnt + 1;
        end else if (busy) begin
            if (cnt == 0) begin
                busy     <= 1'b0;
                cnv_done <= 1'b1;
                cnv_data <= DATA_W'(base[cur] + inc[cur] * smp[cur]);
                smp[cur] <= smp[cur] + 1;
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (epoch != seen_epoch) begin
            seen_epoch <= epoch;
            for (int i = 0; i < 3; i++) smp[i] <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] cfg(input bit cont, input logic [2:0] en,
                                        input logic [2:0] avg, input logic [2:0] t0,
                                        input logic [2:0] t1, input logic [2:0] t2);
        return {t2, t1, t0, avg, cont, en};
    endfunction

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!ready && n < 20000) begin @(negedge clk); n++; end
        check(ready, req, "ready timeout", ready, 1);
    endtask

    task automatic pulse_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(ready == 1'b0, "R1", "ready after reset", ready, 0);
        check(res_shunt == 0 && res_bus == 0 && res_temp == 0, "R1",
              "results after reset", res_shunt, 0);
        repeat (4) @(negedge clk);
        check(start_cnt > 0 && log_ch[0] == 2'd0, "R1", "first request channel",
              log_ch[0], 0);
    endtask

    task automatic t_order();
        int sc;
        @(negedge clk);
        epoch++; base[0] = 1234; base[1] = 777; base[2] = -50;
        cfg_wr = 1'b1; cfg_wdata = cfg(0, 3'b101, 3'd0, 3'd1, 3'd5, 3'd3);
        @(negedge clk); cfg_wr = 1'b0;
        sc = start_cnt;
        wait_ready("R8");
        check(start_cnt - sc == 2, "R2", "request count", start_cnt - sc, 2);
        check(log_ch[sc % 64] == 0 && log_ch[(sc + 1) % 64] == 2, "R2",
              "request order", log_ch[(sc + 1) % 64], 2);
        check(log_t[sc % 64] == 1 && log_t[(sc + 1) % 64] == 3, "R2",
              "time codes", log_t[(sc + 1) % 64], 3);
        check($signed(res_shunt) == 1234, "R3", "shunt raw", $signed(res_shunt), 1234);
        check($signed(res_temp) == -50, "R3", "temp raw", $signed(res_temp), -50);
        check(res_bus == 0, "R5", "disabled bus held", res_bus, 0);
        sc = start_cnt;
        repeat (60) @(negedge clk);
        check(start_cnt == sc, "R6", "single-shot then idle", start_cnt - sc, 0);
        check($signed(res_shunt) == 1234, "R5", "held in shutdown", $signed(res_shunt), 1234);
    endtask

    task automatic t_avg4();
        logic [15:0] p0, p1;
        bit changed = 0;
        @(negedge clk);
        epoch++; base[0] = -7; inc[0] = 3; base[1] = 100; inc[1] = 1;
        cfg_wr = 1'b1; cfg_wdata = cfg(0, 3'b011, 3'd1, 3'd0, 3'd2, 3'd0);
        @(negedge clk); cfg_wr = 1'b0;
        p0 = res_shunt; p1 = res_bus;
        for (int n = 0; n < 5000 && !ready; n++) begin
            if (res_shunt != p0 || res_bus != p1) changed = 1;
            @(negedge clk);
        end
        check(!changed, "R4", "no early publish", changed, 0);
        check(ready, "R8", "ready after averaging", ready, 1);
        check($signed(res_shunt) == -3, "R4", "floor mean shunt", $signed(res_shunt), -3);
        check($signed(res_bus) == 101, "R4", "mean bus", $signed(res_bus), 101);
    endtask

    task automatic t_avg1024();
        @(negedge clk);
        epoch++; base[2] = 0; inc[2] = 1;
        cfg_wr = 1'b1; cfg_wdata = cfg(0, 3'b100, 3'd7, 3'd0, 3'd0, 3'd0);
        @(negedge clk); cfg_wr = 1'b0;
        wait_ready("R4");
        check($signed(res_temp) == 511, "R4", "1024-pass mean", $signed(res_temp), 511);
    endtask

    task automatic t_ready();
        pulse_stat();
        check(ready == 1'b0, "R9", "status read clears", ready, 0);
        @(negedge clk);
        epoch++; base[0] = 9; inc[0] = 0;
        cfg_wr = 1'b1; cfg_wdata = cfg(0, 3'b001, 3'd0, 3'd0, 3'd0, 3'd0);
        @(negedge clk); cfg_wr = 1'b0;
        wait_ready("R8");
        write_cfg(16'h0000);
        check(ready == 1'b1, "R9", "shutdown write keeps ready", ready, 1);
        write_cfg(cfg(0, 3'b001, 3'd0, 3'd0, 3'd0, 3'd0));
        check(ready == 1'b0, "R9", "enabling write clears", ready, 0);
        wait_ready("R8");
    endtask

    task automatic t_cont();
        int sc;
        @(negedge clk);
        epoch++; base[1] = 10; inc[1] = 1;
        cfg_wr = 1'b1; cfg_wdata = cfg(1, 3'b010, 3'd0, 3'd0, 3'd0, 3'd0);
        @(negedge clk); cfg_wr = 1'b0;
        sc = start_cnt;
        repeat (100) @(negedge clk);
        check(start_cnt - sc > 10, "R6", "continuous keeps converting", start_cnt - sc, 11);
        check($signed(res_bus) > 15, "R6", "bus result advancing", $signed(res_bus), 16);
        pulse_stat();
        wait_ready("R6");
    endtask

    task automatic t_abort();
        int sc;
        @(negedge clk);
        epoch++; base[0] = 1000; inc[0] = 0;
        cfg_wr = 1'b1; cfg_wdata = cfg(1, 3'b111, 3'd1, 3'd0, 3'd0, 3'd0);
        @(negedge clk); cfg_wr = 1'b0;
        repeat (15) @(negedge clk);
        epoch++; base[0] = 40;
        cfg_wr = 1'b1; cfg_wdata = cfg(0, 3'b001, 3'd1, 3'd0, 3'd0, 3'd0);
        @(negedge clk); cfg_wr = 1'b0;
        sc = start_cnt;
        wait_ready("R7");
        check(start_cnt - sc == 4, "R7", "restart request count", start_cnt - sc, 4);
        check(log_ch[sc % 64] == 0, "R7", "restart channel", log_ch[sc % 64], 0);
        check($signed(res_shunt) == 40, "R7", "no stale partial sum", $signed(res_shunt), 40);
    endtask

    task automatic t_delay();
        int l0, l6, sc;
        write_cfg(cfg(0, 3'b001, 3'd0, 3'd0, 3'd0, 3'd0));
        l0 = 0;
        while (!cnv_start && l0 < 2000) begin @(negedge clk); l0++; end
        wait_ready("R10");
        sc = start_cnt;
        @(negedge clk); dly_wr = 1'b1; dly_wdata = 8'd6;
        @(negedge clk); dly_wr = 1'b0;
        repeat (30) @(negedge clk);
        check(start_cnt == sc, "R10", "delay write starts nothing", start_cnt - sc, 0);
        write_cfg(cfg(0, 3'b001, 3'd0, 3'd0, 3'd0, 3'd0));
        l6 = 0;
        while (!cnv_start && l6 < 2000) begin @(negedge clk); l6++; end
        check(l6 - l0 == 6 * TICK, "R10", "delay length", l6 - l0, 6 * TICK);
        wait_ready("R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_avg4();
        t_avg1024();
        t_ready();
        t_cont();
        t_abort();
        t_delay();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule